// File: doc/BRIEF.md
# Chip Erase Sequencer for an Electrically Erasable EPROM

This controller carries an external, electrically erasable EPROM through its whole-array erase procedure. One `start` pulse launches it. It first clears every byte to zero. Each byte gets program pulses at program voltage, with a read-back check after each pulse, until the byte reads zero. Only then does it raise both high-voltage enables (the A9 line and the OE/VPP line) with chip enable low, which forms a timed erase pulse. It then drops both enables and waits out a recovery interval and a verify-setup interval. After that it reads the array from address 0 upward and expects every bit to be one.

If the scan meets a byte that is not fully erased, the scan stops at that byte and the next erase pulse follows. Erase attempts are counted. When the count reaches the attempt cap, the device is declared bad. The outcome is reported as a one-cycle `done` pulse together with a `pass` or `fail` level. That level holds until the next `start`.

There is no data stream at this block's edge. `start`, `done`, `pass` and `fail` are plain control and status pins, and `done` has no back-pressure. The memory strobes are active low. The high-voltage enables are meant to drive external supply switches. All durations are given in clock cycles.

Top module: `es_chip_erase_seq`

## Requirements
- R1: After reset, and while idle, `mem_ce_n` and `mem_oe_n` are high, both high-voltage enables are low, `mem_wdata_en` is low, and `done`, `pass` and `fail` are low.
- R2: Before any erase, each address from 0 up to the last one gets program pulses. During a program pulse `vpp_hv_en` is high, `a9_hv_en` is low, `mem_ce_n` is low, and `mem_wdata` = 0x00 is driven with `mem_wdata_en` high. After each pulse the byte is read back. Pulses repeat on the same address until it reads 0x00.
- R3: If one byte still does not read 0x00 after PROG_MAX pulses, the run ends with `fail` and no erase pulse is issued.
- R4: The first erase pulse begins only after every byte has read back 0x00.
- R5: An erase pulse holds `a9_hv_en` and `vpp_hv_en` both high, with `mem_ce_n` low, for exactly ERASE_PULSE_CYC cycles. `a9_hv_en` is never high without `vpp_hv_en`.
- R6: After an erase pulse ends, at least ERASE_RECOV_CYC + VERIFY_SETUP_CYC cycles pass before the next read strobe (`mem_ce_n` and `mem_oe_n` both low). Both high-voltage enables are low whenever `mem_oe_n` is low.
- R7: The erase verify scan reads addresses in ascending order starting at 0 and expects 0xFF. It stops at the first byte that differs, and the next erase pulse follows.
- R8: When a full scan reads every byte as 0xFF, the run ends with `pass`. The number of erase pulses issued equals the number of attempts needed.
- R9: If verify still fails after ERASE_MAX erase pulses, the run ends with `fail`.
- R10: `done` is high for exactly one cycle at the end of a run. At that cycle exactly one of `pass` or `fail` is high. The verdict holds until the next accepted `start`, which clears it.
- R11: A `start` pulse that arrives while a run is in progress has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Erase verified; held until next start |
| fail | output | 1 | Run failed; held until next start |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Program data (always 0x00) |
| mem_wdata_en | output | 1 | Drive enable for `mem_wdata` |
| mem_rdata | input | DW | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| a9_hv_en | output | 1 | High voltage onto the A9 line |
| vpp_hv_en | output | 1 | High voltage onto the OE/VPP line |

## Verification
The hardest states to reach are the boundary attempts. One is a byte that erases only on the very last allowed pulse. Another is a byte that erases one pulse too late. A third is a byte that refuses to clear during pre-program. None of these can be forced through the controller's own pins. The bench therefore models the memory with a per-byte count of program pulses and erase pulses that each byte needs. Directed cases place those counts exactly at and one past the caps, on chosen addresses. Random cases vary the counts so that the verify scan halts at different addresses.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PP_PULSE,
    ST_PP_READ,
    ST_ER_PULSE,
    ST_ER_RECOV,
    ST_EV_SETUP,
    ST_EV_READ,
    ST_DONE
  } es_state_t;

  function automatic int es_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/es_timer.sv
module es_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/es_counter.sv
module es_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/es_pins.sv
module es_pins
  import es_pkg::*;
(
  input  es_state_t st,
  output logic      ce_n,
  output logic      oe_n,
  output logic      a9_hv,
  output logic      vpp_hv,
  output logic      wen
);
  always_comb begin
    ce_n   = 1'b1;
    oe_n   = 1'b1;
    a9_hv  = 1'b0;
    vpp_hv = 1'b0;
    wen    = 1'b0;
    unique case (st)
      ST_PP_PULSE: begin
        ce_n   = 1'b0;
        vpp_hv = 1'b1;
        wen    = 1'b1;
      end
      ST_PP_READ, ST_EV_READ: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_ER_PULSE: begin
        ce_n   = 1'b0;
        a9_hv  = 1'b1;
        vpp_hv = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/es_chip_erase_seq.sv
module es_chip_erase_seq
  import es_pkg::*;
#(
  parameter int AW               = 16,
  parameter int DW               = 8,
  parameter int PROG_PULSE_CYC   = 2500,
  parameter int READ_WAIT_CYC    = 4,
  parameter int PROG_MAX         = 20,
  parameter int ERASE_PULSE_CYC  = 50000000,
  parameter int ERASE_RECOV_CYC  = 50000000,
  parameter int VERIFY_SETUP_CYC = 50000000,
  parameter int ERASE_MAX        = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_en,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          a9_hv_en,
  output logic          vpp_hv_en
);
  localparam int MAXD = es_max(es_max(es_max(PROG_PULSE_CYC, READ_WAIT_CYC),
                                      es_max(ERASE_PULSE_CYC, ERASE_RECOV_CYC)),
                               VERIFY_SETUP_CYC);
  localparam int TW  = $clog2(MAXD + 1);
  localparam int PCW = $clog2(PROG_MAX + 1);
  localparam int ACW = $clog2(ERASE_MAX + 1);
  localparam logic [TW-1:0] T_PROG  = TW'(PROG_PULSE_CYC - 1);
  localparam logic [TW-1:0] T_READ  = TW'(READ_WAIT_CYC - 1);
  localparam logic [TW-1:0] T_ERASE = TW'(ERASE_PULSE_CYC - 1);
  localparam logic [TW-1:0] T_RECOV = TW'(ERASE_RECOV_CYC - 1);
  localparam logic [TW-1:0] T_SETUP = TW'(VERIFY_SETUP_CYC - 1);

  es_state_t state, state_d;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          a_clr, a_inc, p_clr, p_inc, e_clr, e_inc;
  logic          set_pass, set_fail;
  logic [PCW-1:0] pcnt;
  logic [ACW-1:0] ecnt;
  logic          pass_q, fail_q;
  logic          last_addr, byte_zero, byte_ones;

  es_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  es_counter #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc), .q(mem_addr)
  );

  es_counter #(.W(PCW)) u_pcnt (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .q(pcnt)
  );

  es_counter #(.W(ACW)) u_ecnt (
    .clk(clk), .rst_n(rst_n), .clr(e_clr), .inc(e_inc), .q(ecnt)
  );

  es_pins u_pins (
    .st(state), .ce_n(mem_ce_n), .oe_n(mem_oe_n),
    .a9_hv(a9_hv_en), .vpp_hv(vpp_hv_en), .wen(mem_wdata_en)
  );

  assign last_addr = (mem_addr == {AW{1'b1}});
  assign byte_zero = (mem_rdata == '0);
  assign byte_ones = (mem_rdata == {DW{1'b1}});
  assign mem_wdata = '0;

  always_comb begin
    state_d  = state;
    t_load   = 1'b0;
    t_val    = T_PROG;
    a_clr    = 1'b0;
    a_inc    = 1'b0;
    p_clr    = 1'b0;
    p_inc    = 1'b0;
    e_clr    = 1'b0;
    e_inc    = 1'b0;
    set_pass = 1'b0;
    set_fail = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        state_d = ST_PP_PULSE;
        t_load  = 1'b1;
        t_val   = T_PROG;
        a_clr   = 1'b1;
        p_clr   = 1'b1;
        e_clr   = 1'b1;
      end
      ST_PP_PULSE: if (t_exp) begin
        state_d = ST_PP_READ;
        t_load  = 1'b1;
        t_val   = T_READ;
      end
      ST_PP_READ: if (t_exp) begin
        if (byte_zero) begin
          p_clr  = 1'b1;
          t_load = 1'b1;
          if (last_addr) begin
            state_d = ST_ER_PULSE;
            t_val   = T_ERASE;
          end else begin
            state_d = ST_PP_PULSE;
            t_val   = T_PROG;
            a_inc   = 1'b1;
          end
        end else if (int'(pcnt) + 1 >= PROG_MAX) begin
          state_d  = ST_DONE;
          set_fail = 1'b1;
        end else begin
          state_d = ST_PP_PULSE;
          t_load  = 1'b1;
          t_val   = T_PROG;
          p_inc   = 1'b1;
        end
      end
      ST_ER_PULSE: if (t_exp) begin
        state_d = ST_ER_RECOV;
        t_load  = 1'b1;
        t_val   = T_RECOV;
      end
      ST_ER_RECOV: if (t_exp) begin
        state_d = ST_EV_SETUP;
        t_load  = 1'b1;
        t_val   = T_SETUP;
      end
      ST_EV_SETUP: if (t_exp) begin
        state_d = ST_EV_READ;
        t_load  = 1'b1;
        t_val   = T_READ;
        a_clr   = 1'b1;
      end
      ST_EV_READ: if (t_exp) begin
        if (byte_ones) begin
          if (last_addr) begin
            state_d  = ST_DONE;
            set_pass = 1'b1;
          end else begin
            a_inc  = 1'b1;
            t_load = 1'b1;
            t_val  = T_READ;
          end
        end else if (int'(ecnt) + 1 >= ERASE_MAX) begin
          state_d  = ST_DONE;
          set_fail = 1'b1;
        end else begin
          state_d = ST_ER_PULSE;
          t_load  = 1'b1;
          t_val   = T_ERASE;
          e_inc   = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (state == ST_IDLE && start) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (set_pass) begin
      pass_q <= 1'b1;
    end else if (set_fail) begin
      fail_q <= 1'b1;
    end
  end

  assign done = (state == ST_DONE);
  assign pass = pass_q;
  assign fail = fail_q;
endmodule

// File: rtl/es_chip_erase_sva.sv
module es_chip_erase_sva #(
  parameter int PULSE_CYC = 8
) (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic pass,
  input logic fail,
  input logic ce_n,
  input logic oe_n,
  input logic a9_hv,
  input logic vpp_hv,
  input logic wen
);
  int unsigned a9_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     a9_run <= 0;
    else if (a9_hv) a9_run <= a9_run + 1;
    else            a9_run <= 0;
  end

  p_a9_with_vpp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a9_hv |-> (vpp_hv && !ce_n));

  p_erase_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a9_hv) |-> (a9_run == PULSE_CYC));

  p_read_no_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!vpp_hv && !a9_hv && !wen));

  p_drive_only_program_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wen |-> (vpp_hv && !a9_hv && !ce_n));

  p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  p_verdict_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> ($stable(pass) && $stable(fail)));
endmodule

bind es_chip_erase_seq es_chip_erase_sva #(.PULSE_CYC(ERASE_PULSE_CYC)) u_sva (
  .clk(clk), .rst_n(rst_n), .done(done), .pass(pass), .fail(fail),
  .ce_n(mem_ce_n), .oe_n(mem_oe_n), .a9_hv(a9_hv_en), .vpp_hv(vpp_hv_en),
  .wen(mem_wdata_en)
);

// File: tb/sim_es_chip_erase_seq.sv
module sim_es_chip_erase_seq;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int PP = 3;
  localparam int RW = 2;
  localparam int PMAX = 4;
  localparam int EP = 8;
  localparam int RC = 5;
  localparam int SU = 4;
  localparam int EMAX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass, fail, wen, ce_n, oe_n, a9, vpp;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  logic [DW-1:0] mem [N];
  int pneed [N];
  int eneed [N];
  int pcnt  [N];

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  int prog_pulses, erase_pulses, w_cur, w_min, w_max, g_cur, g_min, last_rd;
  bit g_on, pre_bad, drive_bad, prog_prev, er_prev;

  always #5 clk = ~clk;

  es_chip_erase_seq #(
    .AW(AW), .DW(DW), .PROG_PULSE_CYC(PP), .READ_WAIT_CYC(RW), .PROG_MAX(PMAX),
    .ERASE_PULSE_CYC(EP), .ERASE_RECOV_CYC(RC), .VERIFY_SETUP_CYC(SU),
    .ERASE_MAX(EMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .fail(fail),
    .mem_addr(addr), .mem_wdata(wdata), .mem_wdata_en(wen), .mem_rdata(rdata),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .a9_hv_en(a9), .vpp_hv_en(vpp)
  );

  assign rdata = (!ce_n && !oe_n) ? mem[addr] : 8'hA5;

  // memory model, sampled away from the active edge
  always @(negedge clk) begin
    bit prog_now, er_now, rd_now;
    cyc++;
    prog_now = vpp && !a9 && !ce_n;
    er_now   = vpp && a9 && !ce_n;
    rd_now   = !ce_n && !oe_n;
    if (prog_now && (!wen || wdata != 8'h00)) drive_bad = 1'b1;
    if (prog_now && !prog_prev) begin
      prog_pulses++;
      pcnt[addr]++;
      if (pcnt[addr] >= pneed[addr]) mem[addr] = mem[addr] & wdata;
    end
    if (er_now && !er_prev) begin
      erase_pulses++;
      if (erase_pulses == 1)
        for (int i = 0; i < N; i++) if (mem[i] != 8'h00) pre_bad = 1'b1;
      for (int i = 0; i < N; i++) if (erase_pulses >= eneed[i]) mem[i] = 8'hFF;
    end
    if (er_now) w_cur++;
    else if (er_prev) begin
      if (w_cur < w_min) w_min = w_cur;
      if (w_cur > w_max) w_max = w_cur;
      w_cur = 0;
      g_on  = 1'b1;
      g_cur = 0;
    end
    if (g_on) begin
      if (rd_now) begin
        if (g_cur < g_min) g_min = g_cur;
        g_on = 1'b0;
      end else g_cur++;
    end
    if (rd_now && erase_pulses > 0) last_rd = addr;
    prog_prev = prog_now;
    er_prev   = er_now;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input string name, input bit extra_start);
    int pre_idx, psum, emax, exp_ep, exp_last, waited;
    bit exp_pass, p0, f0;
    pre_idx = -1; psum = 0; emax = 0; exp_last = N - 1;
    for (int i = 0; i < N; i++) begin
      if (pneed[i] > PMAX) begin pre_idx = i; psum += PMAX; break; end
      psum += pneed[i];
    end
    for (int i = 0; i < N; i++) if (eneed[i] > emax) emax = eneed[i];
    if (pre_idx >= 0) begin
      exp_pass = 1'b0; exp_ep = 0;
    end else begin
      exp_pass = (emax <= EMAX);
      exp_ep   = exp_pass ? emax : EMAX;
      if (!exp_pass)
        for (int i = N - 1; i >= 0; i--) if (eneed[i] > EMAX) exp_last = i;
    end
    for (int i = 0; i < N; i++) begin
      mem[i]  = 8'($urandom) | 8'h01;
      pcnt[i] = 0;
    end
    prog_pulses = 0; erase_pulses = 0; w_cur = 0; w_min = 1 << 30; w_max = 0;
    g_min = 1 << 30; g_on = 1'b0; pre_bad = 1'b0; drive_bad = 1'b0; last_rd = -1;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!pass && !fail, "R10", {name, " verdict cleared by start"}, {pass, fail}, 0);
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
      if (extra_start) start = (waited == 30 || waited == 31);
    end
    start = 1'b0;
    chk(waited < 20000, "R10", {name, " done reached"}, waited, 0);
    chk(pass == exp_pass && fail == !exp_pass, exp_pass ? "R8" : (pre_idx >= 0 ? "R3" : "R9"),
        {name, " verdict"}, {pass, fail}, {exp_pass, !exp_pass});
    chk(prog_pulses == psum, "R2", {name, " program pulse count"}, prog_pulses, psum);
    chk(!drive_bad, "R2", {name, " program data 0x00 driven"}, drive_bad, 0);
    chk(erase_pulses == exp_ep, extra_start ? "R11" : "R8", {name, " erase pulse count"},
        erase_pulses, exp_ep);
    chk(!pre_bad, "R4", {name, " array zero before erase"}, pre_bad, 0);
    if (exp_ep > 0) begin
      chk(w_min == EP && w_max == EP, "R5", {name, " erase pulse width"}, w_max, EP);
      chk(g_min >= RC + SU, "R6", {name, " recovery+setup gap"}, g_min, RC + SU);
      chk(last_rd == exp_last, "R7", {name, " scan stop address"}, last_rd, exp_last);
    end
    p0 = pass; f0 = fail;
    @(negedge clk);
    chk(!done, "R10", {name, " done one cycle"}, done, 0);
    repeat (3) @(negedge clk);
    chk(pass == p0 && fail == f0, "R10", {name, " verdict held"}, {pass, fail}, {p0, f0});
    chk(ce_n && oe_n && !a9 && !vpp && !wen, "R1", {name, " idle pins"}, {ce_n, oe_n}, 3);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    for (int i = 0; i < N; i++) begin pneed[i] = 1; eneed[i] = 1; mem[i] = 8'h11; pcnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !a9 && !vpp && !wen, "R1", "pins in reset", {ce_n, oe_n, a9, vpp}, 12);
    chk(!done && !pass && !fail, "R1", "status in reset", {done, pass, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n && oe_n && !a9 && !vpp && !wen && !done, "R1", "idle after reset", {ce_n, oe_n}, 3);

    run("base", 1'b0);

    for (int i = 0; i < N; i++) begin pneed[i] = 1 + ($urandom % PMAX); eneed[i] = 2; end
    eneed[9] = EMAX;
    run("last_attempt", 1'b1);

    for (int i = 0; i < N; i++) begin pneed[i] = 1; eneed[i] = 1; end
    eneed[3] = EMAX + 1; eneed[11] = EMAX + 1;
    run("erase_cap", 1'b0);

    for (int i = 0; i < N; i++) begin pneed[i] = PMAX; eneed[i] = 1; end
    pneed[5] = PMAX + 1;
    run("preprog_stuck", 1'b0);

    for (int i = 0; i < N; i++) begin pneed[i] = PMAX; eneed[i] = 1 + ($urandom % 3); end
    run("preprog_limit", 1'b0);

    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < N; i++) begin
        pneed[i] = (($urandom % 40) == 0) ? PMAX + 1 : 1 + ($urandom % PMAX);
        eneed[i] = (($urandom % 6) == 0) ? 1 + ($urandom % (EMAX + 1)) : 1 + ($urandom % 3);
      end
      run($sformatf("rand%0d", r), r[0]);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule